// File: doc/BRIEF.md
# Masked Line Write Burst Engine

This block turns one narrow or partial store into a write burst on a 64-bit memory data bus. A store names a byte address and a byte count, and brings a line-sized payload whose bytes sit at their positions in the 64-byte line. The block works out which byte lanes the store covers. It then emits the line as beats of 8 bytes, with a per-lane write strobe on each beat, so that memory changes only the lanes the store covers.

When every covered byte falls in one aligned 32-byte half of the line, the burst is cut to the 4 beats of that half. When the mode input reports that per-lane masking is not available, the block works another way. It requests the old line, collects 8 returned read beats and merges the new bytes over them. It then writes the complete line with every lane enabled. A store that runs past the end of its line is refused with an error pulse. A store of zero bytes completes at once, and neither case touches the bus.

Top module: `masked_burst_writer`

## Requirements
- R1: Write beat k carries line bytes 8k to 8k+7 (lane j of `wr_data` is bits 8j+7:8j) and reports k on `wr_beat`. Beats run in ascending order on consecutive cycles, with `wr_first` on the first and `wr_last` on the final beat, and `wr_addr` gives the line address with its low 6 bits at zero.
- R2: The covered bytes are line offsets from `req_addr[5:0]` up to `req_addr[5:0] + req_size - 1`. In masked mode a store whose covered bytes touch both halves produces 8 beats (0 to 7) with `wr_chop` low. Bit j of `wr_strb` on beat k is set exactly when line byte 8k+j is covered.
- R3: In masked mode, if all covered bytes lie in bytes 0 to 31 the burst is beats 0 to 3. If all lie in bytes 32 to 63 it is beats 4 to 7. In both cases `wr_chop` is high on every beat.
- R4: With masking off, `rd_req` pulses for one cycle with `rd_addr` set to the line address. Beat i of the returned line is taken on each cycle with `rd_valid` high (bytes 8i to 8i+7, in order, gaps allowed). The write starts the cycle after the 8th read beat. It has 8 beats with `wr_strb` all ones, each byte being the new byte where covered and the old byte elsewhere.
- R5: `mask_en` (1 = masked bursts, 0 = read-merge-write) is taken at acceptance. A masked store starts its first beat in the cycle after acceptance, and later changes of `mask_en` do not affect a store in progress.
- R6: If `req_addr[5:0] + req_size` exceeds 64, `err` pulses in the cycle after acceptance, with no write beat, no read request and no `done`.
- R7: A store with `req_size` zero raises `done` in the cycle after acceptance and generates no bus activity.
- R8: `req_ready` is high only while idle. It is low from the cycle after acceptance through the last write beat. `done` pulses for one cycle right after the last write beat, when `req_ready` is high again.
- R9: While `rst_n` is low at a clock edge, `req_ready` goes high and `wr_valid`, `rd_req`, `done` and `err` go low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Store request valid |
| req_ready | output | 1 | Engine idle and able to accept |
| req_addr | input | ADDR_W | Byte address of the first stored byte |
| req_size | input | 7 | Number of bytes stored, 0 to 64 |
| req_data | input | 512 | New line bytes at their line positions |
| mask_en | input | 1 | 1: masked bursts; 0: read-merge-write |
| wr_valid | output | 1 | Write beat valid |
| wr_addr | output | ADDR_W | Line address of the burst |
| wr_beat | output | 3 | Index of the current beat within the line |
| wr_first | output | 1 | First beat of the burst |
| wr_last | output | 1 | Last beat of the burst |
| wr_chop | output | 1 | Burst is the 4-beat half-line form |
| wr_data | output | 64 | Beat data |
| wr_strb | output | 8 | Per-lane write strobe, 1 = write |
| rd_req | output | 1 | One-cycle request to read the old line |
| rd_addr | output | ADDR_W | Line address to read |
| rd_valid | input | 1 | Read beat valid |
| rd_data | input | 64 | Read beat data |
| done | output | 1 | Store completed |
| err | output | 1 | Store refused for crossing the line end |

## Verification
On every cycle the assertions check several rules. Beats must step upward without a gap until the last one. A full burst must end on beat 7. The engine must refuse new stores while it is driving the bus. A refused store must stay silent, and a read request must last one cycle. Merged writes must enable every lane, and `done` must follow the final beat. Only the scenarios can show that the strobes match the covered bytes and that the chop picks the correct half. They also show that merged bytes mix old and new data correctly, and that the write waits for a read stream with gaps.

// File: rtl/mbw_pkg.sv
// Shared types for the masked line write burst engine.
// Assumes nothing beyond a single clock domain.
package mbw_pkg;
    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_WRITE  = 2'd1,
        ST_RDREQ  = 2'd2,
        ST_RDWAIT = 2'd3
    } mbw_state_e;
endpackage

// File: rtl/mbw_lane_mask.sv
// Lane coverage decoder: turns a line offset and a byte count into a
// per-byte enable vector and classifies the store (empty, crosses the
// line end, confined to the low or the high half).
// Assumes LINE_BYTES is a power of two and the count fits SIZE_W bits.
module mbw_lane_mask #(
    parameter int LINE_BYTES = 64,
    localparam int OFF_W     = $clog2(LINE_BYTES),
    localparam int SIZE_W    = OFF_W + 1,
    localparam int HALF      = LINE_BYTES / 2
) (
    input  logic [OFF_W-1:0]      off,
    input  logic [SIZE_W-1:0]     size,
    output logic [LINE_BYTES-1:0] be,
    output logic                  span_err,
    output logic                  empty,
    output logic                  lo_only,
    output logic                  hi_only
);
    logic [SIZE_W:0] start_pos;
    logic [SIZE_W:0] end_pos;

    // first covered offset and one past the last covered offset
    assign start_pos = {2'b00, off};
    assign end_pos   = {2'b00, off} + {1'b0, size};

    // one comparator pair per lane
    for (genvar i = 0; i < LINE_BYTES; i++) begin : g_lane
        localparam logic [SIZE_W:0] LANE = (SIZE_W+1)'(i);
        assign be[i] = (start_pos <= LANE) && (LANE < end_pos);
    end

    // store classification
    assign empty    = (size == '0);
    assign span_err = (end_pos > (SIZE_W+1)'(LINE_BYTES));
    assign lo_only  = ~|be[LINE_BYTES-1:HALF];
    assign hi_only  = ~|be[HALF-1:0];
endmodule

// File: rtl/mbw_merge.sv
// Byte merge for one beat: keeps the new byte on covered lanes and the
// old byte returned by memory on the others.
// Assumes keep[j] guards bits 8j+7:8j of both data inputs.
module mbw_merge #(
    parameter int BEAT_BYTES = 8,
    localparam int BEAT_BITS = 8 * BEAT_BYTES
) (
    input  logic [BEAT_BITS-1:0]  new_beat,
    input  logic [BEAT_BYTES-1:0] keep,
    input  logic [BEAT_BITS-1:0]  old_beat,
    output logic [BEAT_BITS-1:0]  merged
);
    // one byte mux per lane
    for (genvar j = 0; j < BEAT_BYTES; j++) begin : g_byte
        assign merged[8*j +: 8] = keep[j] ? new_beat[8*j +: 8] : old_beat[8*j +: 8];
    end
endmodule

// File: rtl/masked_burst_writer.sv
// Masked line write burst engine.
// Accepts one store at a time, holds the line and its lane enables, and
// drives either a masked burst (full or half line) or a read, merge and
// full-line write. Assumes the memory side accepts one beat per cycle and
// returns read beats in ascending order.
module masked_burst_writer #(
    parameter int BEAT_BYTES = 8,
    parameter int LINE_BEATS = 8,
    parameter int ADDR_W     = 32,
    localparam int LINE_BYTES = BEAT_BYTES * LINE_BEATS,
    localparam int LINE_BITS  = 8 * LINE_BYTES,
    localparam int BEAT_BITS  = 8 * BEAT_BYTES,
    localparam int OFF_W      = $clog2(LINE_BYTES),
    localparam int SIZE_W     = OFF_W + 1,
    localparam int BEAT_W     = $clog2(LINE_BEATS),
    localparam int HALF_BEATS = LINE_BEATS / 2
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  req_valid,
    output logic                  req_ready,
    input  logic [ADDR_W-1:0]     req_addr,
    input  logic [SIZE_W-1:0]     req_size,
    input  logic [LINE_BITS-1:0]  req_data,
    input  logic                  mask_en,
    output logic                  wr_valid,
    output logic [ADDR_W-1:0]     wr_addr,
    output logic [BEAT_W-1:0]     wr_beat,
    output logic                  wr_first,
    output logic                  wr_last,
    output logic                  wr_chop,
    output logic [BEAT_BITS-1:0]  wr_data,
    output logic [BEAT_BYTES-1:0] wr_strb,
    output logic                  rd_req,
    output logic [ADDR_W-1:0]     rd_addr,
    input  logic                  rd_valid,
    input  logic [BEAT_BITS-1:0]  rd_data,
    output logic                  done,
    output logic                  err
);
    import mbw_pkg::*;

    localparam logic [BEAT_W-1:0] BEAT_MAX  = BEAT_W'(LINE_BEATS - 1);
    localparam logic [BEAT_W-1:0] HALF_LAST = BEAT_W'(HALF_BEATS - 1);
    localparam logic [BEAT_W-1:0] HALF_FIRST = BEAT_W'(HALF_BEATS);

    mbw_state_e             state_q;
    logic [LINE_BITS-1:0]   line_q;
    logic [LINE_BYTES-1:0]  be_q;
    logic [ADDR_W-1:0]      addr_q;
    logic                   rmw_q;
    logic                   chop_q;
    logic                   first_q;
    logic [BEAT_W-1:0]      beat_q;
    logic [BEAT_W-1:0]      last_beat_q;
    logic                   done_q;
    logic                   err_q;

    logic [LINE_BYTES-1:0]  req_be;
    logic                   req_span_err;
    logic                   req_empty;
    logic                   req_lo_only;
    logic                   req_hi_only;
    logic [BEAT_BITS-1:0]   cur_beat;
    logic [BEAT_BYTES-1:0]  cur_be;
    logic [BEAT_BITS-1:0]   merged_beat;

    // decode lane coverage of the incoming store
    mbw_lane_mask #(.LINE_BYTES(LINE_BYTES)) u_lane_mask (
        .off      (req_addr[OFF_W-1:0]),
        .size     (req_size),
        .be       (req_be),
        .span_err (req_span_err),
        .empty    (req_empty),
        .lo_only  (req_lo_only),
        .hi_only  (req_hi_only)
    );

    // select the held beat and its enables
    assign cur_beat = line_q[beat_q*BEAT_BITS +: BEAT_BITS];
    assign cur_be   = be_q[beat_q*BEAT_BYTES +: BEAT_BYTES];

    // overlay new bytes on the returned old beat
    mbw_merge #(.BEAT_BYTES(BEAT_BYTES)) u_merge (
        .new_beat (cur_beat),
        .keep     (cur_be),
        .old_beat (rd_data),
        .merged   (merged_beat)
    );

    // sequencer: accept, read and merge, burst out, complete
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q     <= ST_IDLE;
            line_q      <= '0;
            be_q        <= '0;
            addr_q      <= '0;
            rmw_q       <= 1'b0;
            chop_q      <= 1'b0;
            first_q     <= 1'b0;
            beat_q      <= '0;
            last_beat_q <= '0;
            done_q      <= 1'b0;
            err_q       <= 1'b0;
        end else begin
            done_q <= 1'b0;
            err_q  <= 1'b0;
            unique case (state_q)
                ST_IDLE: begin
                    if (req_valid) begin
                        if (req_empty) begin
                            done_q <= 1'b1;
                        end else if (req_span_err) begin
                            err_q <= 1'b1;
                        end else begin
                            line_q  <= req_data;
                            be_q    <= req_be;
                            addr_q  <= {req_addr[ADDR_W-1:OFF_W], {OFF_W{1'b0}}};
                            rmw_q   <= !mask_en;
                            first_q <= 1'b1;
                            if (mask_en) begin
                                state_q     <= ST_WRITE;
                                chop_q      <= req_lo_only || req_hi_only;
                                beat_q      <= req_hi_only ? HALF_FIRST : '0;
                                last_beat_q <= req_lo_only ? HALF_LAST : BEAT_MAX;
                            end else begin
                                state_q     <= ST_RDREQ;
                                chop_q      <= 1'b0;
                                beat_q      <= '0;
                                last_beat_q <= BEAT_MAX;
                            end
                        end
                    end
                end
                ST_WRITE: begin
                    first_q <= 1'b0;
                    beat_q  <= beat_q + 1'b1;
                    if (beat_q == last_beat_q) begin
                        state_q <= ST_IDLE;
                        done_q  <= 1'b1;
                    end
                end
                ST_RDREQ: begin
                    state_q <= ST_RDWAIT;
                end
                ST_RDWAIT: begin
                    if (rd_valid) begin
                        line_q[beat_q*BEAT_BITS +: BEAT_BITS] <= merged_beat;
                        if (beat_q == BEAT_MAX) begin
                            beat_q  <= '0;
                            state_q <= ST_WRITE;
                        end else begin
                            beat_q <= beat_q + 1'b1;
                        end
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    // port outputs decoded from held state
    assign req_ready = (state_q == ST_IDLE);
    assign wr_valid  = (state_q == ST_WRITE);
    assign wr_addr   = addr_q;
    assign wr_beat   = beat_q;
    assign wr_first  = wr_valid && first_q;
    assign wr_last   = wr_valid && (beat_q == last_beat_q);
    assign wr_chop   = wr_valid && chop_q;
    assign wr_data   = cur_beat;
    assign wr_strb   = rmw_q ? {BEAT_BYTES{1'b1}} : cur_be;
    assign rd_req    = (state_q == ST_RDREQ);
    assign rd_addr   = addr_q;
    assign done      = done_q;
    assign err       = err_q;

    AST_BEAT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid && !wr_last) |=> (wr_valid && wr_beat == $past(wr_beat) + 1'b1)); // R1
    AST_FULL_ENDS_TOP: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_last && !wr_chop) |-> (wr_beat == BEAT_MAX)); // R2
    AST_MERGE_ALL_LANES: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid && rmw_q) |-> (&wr_strb)); // R4
    AST_RD_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req |=> !rd_req); // R4
    AST_ERR_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> (!wr_valid && !rd_req && !done)); // R6
    AST_BUSY_NOT_READY: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid || rd_req) |-> !req_ready); // R8
    AST_DONE_AFTER_LAST: assert property (@(posedge clk) disable iff (!rst_n)
        wr_last |=> (done && req_ready)); // R8
endmodule

// File: tb/masked_burst_writer_tb.sv
// Bench: behavioural model queues expected write beats per store and a
// monitor compares every cycle's bus activity against it.
module masked_burst_writer_tb;
    logic         clk = 1'b0;
    logic         rst_n;
    logic         req_valid;
    logic         req_ready;
    logic [31:0]  req_addr;
    logic [6:0]   req_size;
    logic [511:0] req_data;
    logic         mask_en;
    logic         wr_valid;
    logic [31:0]  wr_addr;
    logic [2:0]   wr_beat;
    logic         wr_first, wr_last, wr_chop;
    logic [63:0]  wr_data;
    logic [7:0]   wr_strb;
    logic         rd_req;
    logic [31:0]  rd_addr;
    logic         rd_valid;
    logic [63:0]  rd_data;
    logic         done, err;

    int checks = 0;
    int errors = 0;

    typedef struct packed {
        logic [31:0] addr;
        logic [2:0]  beat;
        logic [7:0]  strb;
        logic [63:0] data;
        logic        chop;
        logic        first;
        logic        last;
    } beat_t;

    beat_t exp_q[$];

    always #10 clk = ~clk;

    masked_burst_writer u_dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_addr(req_addr), .req_size(req_size), .req_data(req_data), .mask_en(mask_en),
        .wr_valid(wr_valid), .wr_addr(wr_addr), .wr_beat(wr_beat), .wr_first(wr_first),
        .wr_last(wr_last), .wr_chop(wr_chop), .wr_data(wr_data), .wr_strb(wr_strb),
        .rd_req(rd_req), .rd_addr(rd_addr), .rd_valid(rd_valid), .rd_data(rd_data),
        .done(done), .err(err)
    );

    task automatic check(input bit ok, input string req, input logic [127:0] act,
                         input logic [127:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    function automatic logic [63:0] keep_lanes(input logic [63:0] d, input logic [7:0] s);
        logic [63:0] r;
        for (int j = 0; j < 8; j++) r[8*j +: 8] = s[j] ? d[8*j +: 8] : 8'h00;
        return r;
    endfunction

    function automatic logic [511:0] rand_line();
        logic [511:0] r;
        for (int w = 0; w < 16; w++) r[32*w +: 32] = $urandom;
        return r;
    endfunction

    // monitor: every write beat must match the head of the model queue (R1)
    always @(negedge clk) begin
        if (rst_n && wr_valid) begin
            beat_t act;
            act = '{addr: wr_addr, beat: wr_beat, strb: wr_strb,
                    data: keep_lanes(wr_data, wr_strb), chop: wr_chop,
                    first: wr_first, last: wr_last};
            if (exp_q.size() == 0) begin
                check(1'b0, "R2 unexpected beat", 128'(act), 128'(0));
            end else begin
                beat_t e;
                e = exp_q.pop_front();
                check(act == e, "R1 beat", 128'(act), 128'(e));
            end
            check(!req_ready, "R8 ready while bursting", 128'(req_ready), 128'(0));
        end
    end

    task automatic wait_done(input string req);
        int guard = 0;
        while (!done && guard < 100) begin
            @(negedge clk);
            guard++;
        end
        check(done, req, 128'(done), 128'(1));
        check(req_ready, "R8 ready with done", 128'(req_ready), 128'(1));
        check(exp_q.size() == 0, "R2 burst length", 128'(exp_q.size()), 128'(0));
    endtask

    task automatic run_req(input logic [31:0] addr, input int size,
                           input logic [511:0] data, input bit mask,
                           input logic [511:0] old);
        int off, endp, first_b, last_b;
        bit lo, hi;
        logic [63:0] en;
        logic [31:0] line;
        off  = int'(addr[5:0]);
        endp = off + size;
        line = {addr[31:6], 6'd0};
        lo   = (endp <= 32);
        hi   = (off >= 32);
        for (int b = 0; b < 64; b++) en[b] = (b >= off) && (b < endp);
        while (!req_ready) @(negedge clk);
        if (size != 0 && endp <= 64) begin
            if (mask) begin
                first_b = hi ? 4 : 0;
                last_b  = lo ? 3 : 7;
                for (int k = first_b; k <= last_b; k++)
                    exp_q.push_back('{addr: line, beat: 3'(k), strb: en[8*k +: 8],
                        data: keep_lanes(data[64*k +: 64], en[8*k +: 8]),
                        chop: lo || hi, first: (k == first_b), last: (k == last_b)});
            end else begin
                for (int k = 0; k < 8; k++) begin
                    logic [63:0] m;
                    for (int j = 0; j < 8; j++)
                        m[8*j +: 8] = en[8*k+j] ? data[64*k+8*j +: 8] : old[64*k+8*j +: 8];
                    exp_q.push_back('{addr: line, beat: 3'(k), strb: 8'hFF, data: m,
                        chop: 1'b0, first: (k == 0), last: (k == 7)});
                end
            end
        end
        req_valid = 1'b1;
        req_addr  = addr;
        req_size  = 7'(size);
        req_data  = data;
        mask_en   = mask;
        @(negedge clk);
        req_valid = 1'b0;
        req_data  = rand_line();
        mask_en   = !mask;              // R5: late change must not matter
        if (size == 0) begin
            check(done && !err, "R7 empty store done", 128'({done, err}), 128'(2'b10));
            for (int c = 0; c < 3; c++) begin
                check(!wr_valid && !rd_req, "R7 no bus activity", 128'({wr_valid, rd_req}), 128'(0));
                @(negedge clk);
            end
        end else if (endp > 64) begin
            check(err && !done, "R6 error pulse", 128'({err, done}), 128'(2'b10));
            for (int c = 0; c < 3; c++) begin
                check(!wr_valid && !rd_req && !done, "R6 silent", 128'({wr_valid, rd_req, done}), 128'(0));
                @(negedge clk);
            end
        end else if (mask) begin
            check(wr_valid && wr_first && !rd_req, "R5 masked burst starts", 128'({wr_valid, wr_first, rd_req}), 128'(3'b110));
            wait_done(lo || hi ? "R3 chopped done" : "R2 full done");
        end else begin
            check(rd_req && rd_addr == line && !wr_valid, "R4 read request",
                  128'({rd_req, wr_valid, rd_addr}), 128'({1'b1, 1'b0, line}));
            @(negedge clk);
            check(!rd_req, "R4 single read pulse", 128'(rd_req), 128'(0));
            for (int i = 0; i < 8; i++) begin
                if (i == 3) begin
                    rd_valid = 1'b0;
                    @(negedge clk);
                end
                rd_valid = 1'b1;
                rd_data  = old[64*i +: 64];
                check(!wr_valid && !req_ready, "R4 no write before read done", 128'({wr_valid, req_ready}), 128'(0));
                @(negedge clk);
            end
            rd_valid = 1'b0;
            rd_data  = '0;
            check(wr_valid && wr_beat == 3'd0, "R4 write after 8th beat", 128'({wr_valid, wr_beat}), 128'({1'b1, 3'd0}));
            wait_done("R4 merged done");
        end
    endtask

    initial begin
        #(20 * 200000);
        errors++;
        checks++;
        $display("FAIL watchdog R8 act=hung exp=finished");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        rst_n     = 1'b0;
        req_valid = 1'b0;
        req_addr  = '0;
        req_size  = '0;
        req_data  = '0;
        mask_en   = 1'b1;
        rd_valid  = 1'b0;
        rd_data   = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check(req_ready && !wr_valid && !rd_req && !done && !err, "R9 reset state",
              128'({req_ready, wr_valid, rd_req, done, err}), 128'(5'b10000));
        rst_n = 1'b1;
        @(negedge clk);

        run_req(32'h1000_0014, 1,  rand_line(), 1'b1, '0);       // R3 low half
        run_req(32'h1000_006D, 3,  rand_line(), 1'b1, '0);       // R3 high half
        run_req(32'h1000_009C, 10, rand_line(), 1'b1, '0);       // R2 crosses halves
        run_req(32'h1000_00C0, 64, rand_line(), 1'b1, '0);       // R2 full line
        run_req(32'h1000_0121, 31, rand_line(), 1'b1, '0);       // R3 ends at line end
        run_req(32'h1000_0140, 32, rand_line(), 1'b1, '0);       // R3 exact low half
        run_req(32'h2000_004D, 5,  rand_line(), 1'b0, rand_line()); // R4 merge
        run_req(32'h2000_0080, 64, rand_line(), 1'b0, rand_line()); // R4 full merge
        run_req(32'h2000_00FC, 8,  rand_line(), 1'b1, '0);       // R6 crosses line end
        run_req(32'h2000_0101, 64, rand_line(), 1'b0, '0);       // R6 in merge mode
        run_req(32'h2000_0155, 0,  rand_line(), 1'b1, '0);       // R7 empty
        for (int n = 0; n < 12; n++) begin
            int o, s;
            o = int'($urandom % 64);
            s = 1 + int'($urandom % (64 - o));
            run_req(32'h3000_0000 + 32'(n * 64 + o), s, rand_line(), n[0], rand_line());
        end
        repeat (2) @(negedge clk);
        check(exp_q.size() == 0, "R1 all beats seen", 128'(exp_q.size()), 128'(0));
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule